// File: doc/BRIEF.md
# Coherent Interconnect Event Counter Unit

This block counts coherent traffic arriving on the upstream interfaces of a cache-coherent interconnect. Every cycle each upstream lane can present one already-decoded transaction: a valid strobe, a 4-bit transaction-type code and a secure attribute. A fixed table turns the code into an event number. Each of eight counters picks one event number, and either one lane or all lanes. When several lanes carry a matching event in the same cycle, the counter adds all of them at once.

Counting obeys debug authentication. Nothing counts while the invasive debug enable is low. Secure transactions count only when the secure invasive enable is also high. Non-secure transactions count only when non-secure monitoring is permitted.

Software configures, reads, preloads and clears the counters through a single-cycle request port that takes word accesses only. Each counter has a sticky wrap flag, and each flag drives its own output pin.

Top module: `ic_evt_monitor`

## Requirements
- R1: Transaction codes map to event numbers as follows: 0 (ReadOnce) → 3; 1..4 (ReadClean, ReadShared, ReadNotSharedDirty, ReadUnique) → 4; 5..6 (MakeUnique, CleanUnique) → 5; 7..9 (CleanInvalid, CleanShared, MakeInvalid) → 6; 10 (DVM) → 7; 11 (read data satisfied by a snoop) → 9. Codes 12..15 raise no event, and event numbers other than 3, 4, 5, 6, 7 and 9 never count.
- R2: Each counter selects an event number (config bits [12:8]) and either one lane (bits [22:20]) or any lane (bit 16). In each cycle it adds the number of matching valid lanes, and the new value is readable from the following cycle.
- R3: A counter advances only while the global enable (control bit 0) and its own enable (config bit 0) are both 1.
- R4: While `dbg_inv_en` is 0, no counter advances.
- R5: A secure lane counts only when `dbg_inv_en` and `dbg_sec_en` are both 1. A non-secure lane counts only when `dbg_inv_en` and `dbg_ns_en` are both 1.
- R6: A counter that wraps past all-ones sets its sticky flag, shown on `cnt_ovf[i]` and in bit i of the flag register (index 1). Writing 1 to that bit clears the flag. If a wrap and a clear land in the same cycle, the wrap wins.
- R7: Writing 1 to control bit 1 zeroes every counter. The bit always reads 0, and the write leaves the wrap flags unchanged.
- R8: Only accesses with `reg_size` = 2 (word) take effect. Byte (0) and halfword (1) writes change nothing, and reads of those sizes return 0.
- R9: A read request is answered one cycle later with `reg_rvalid` = 1. The register indices are: control = 0, flags = 1, config i = 8+i, value i = 16+i. Unused bits and unmapped indices read 0.
- R10: After reset, all counters, configs, flags, the global enable and `reg_rvalid` are 0.
- R11: A word write to value register 16+i loads counter i. If an event matches in the same cycle, the load wins over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_vld | input | NUM_PORTS | Per-lane transaction valid |
| up_txn | input | NUM_PORTS*4 | Per-lane transaction-type code, lane p at bits [4p+3:4p] |
| up_sec | input | NUM_PORTS | Per-lane secure attribute (1 = secure) |
| dbg_inv_en | input | 1 | Invasive debug enable |
| dbg_sec_en | input | 1 | Secure invasive debug enable |
| dbg_ns_en | input | 1 | Non-secure monitoring permitted |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 5 | Register word index |
| reg_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| cnt_ovf | output | NUM_CNT | Sticky per-counter wrap flags |

## Verification
The mapping is first exercised by sending all sixteen codes, one per cycle, on a single non-secure lane. The counters set to different event numbers must then each hold the exact number of codes that map to them, which exposes any code sent to the wrong event and any unused event that wrongly counts. Next, every lane fires at once, and then two lanes fire together. These cases separate adding the number of hits from adding one per cycle, and show whether the single-lane and any-lane selections behave differently. Mixed secure and non-secure pairs are replayed under each setting of the three debug inputs, so each gating term can be told apart. Loads and flag clears are placed in the same cycle as a matching event to settle which one has priority.

// File: rtl/ic_evt_pkg.sv
// Shared widths, register indices and the transaction-to-event table.
// Assumes transaction codes arrive already decoded into a 4-bit value.
package ic_evt_pkg;
    localparam int TXN_W  = 4;
    localparam int EVT_W  = 5;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;
    localparam logic [1:0] SIZE_WORD = 2'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL = 5'd0;
    localparam logic [IDX_W-1:0] IDX_OVF  = 5'd1;
    localparam int CFG_BASE = 8;
    localparam int VAL_BASE = 16;
    // config word field positions
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_EVT_LSB  = 8;
    localparam int CFG_ANY_BIT  = 16;
    localparam int CFG_PORT_LSB = 20;

    typedef enum logic [TXN_W-1:0] {
        TXN_RD_ONCE      = 4'd0,
        TXN_RD_CLEAN     = 4'd1,
        TXN_RD_SHARED    = 4'd2,
        TXN_RD_NSD       = 4'd3,
        TXN_RD_UNIQUE    = 4'd4,
        TXN_MK_UNIQUE    = 4'd5,
        TXN_CLN_UNIQUE   = 4'd6,
        TXN_CLN_INVALID  = 4'd7,
        TXN_CLN_SHARED   = 4'd8,
        TXN_MK_INVALID   = 4'd9,
        TXN_DVM          = 4'd10,
        TXN_SNOOP_DATA   = 4'd11
    } txn_e;

    // Map a transaction code to its event number; 0 means no event.
    function automatic logic [EVT_W-1:0] evt_of(input logic [TXN_W-1:0] code);
        logic [EVT_W-1:0] ev;
        case (code)
            TXN_RD_ONCE:                                           ev = 5'd3;
            TXN_RD_CLEAN, TXN_RD_SHARED, TXN_RD_NSD, TXN_RD_UNIQUE: ev = 5'd4;
            TXN_MK_UNIQUE, TXN_CLN_UNIQUE:                         ev = 5'd5;
            TXN_CLN_INVALID, TXN_CLN_SHARED, TXN_MK_INVALID:       ev = 5'd6;
            TXN_DVM:                                               ev = 5'd7;
            TXN_SNOOP_DATA:                                        ev = 5'd9;
            default:                                               ev = 5'd0;
        endcase
        return ev;
    endfunction
endpackage

// File: rtl/ic_evt_lane_decode.sv
// Per-lane event decoder with debug-authentication gating.
// Purely combinational; one lane per upstream interface. A lane is
// reported only when it is valid, maps to a real event and its
// security attribute is permitted by the debug enables.
module ic_evt_lane_decode
    import ic_evt_pkg::*;
#(
    parameter int NUM_PORTS = 7
) (
    input  logic [NUM_PORTS-1:0]       lane_vld,
    input  logic [NUM_PORTS*TXN_W-1:0] lane_txn,
    input  logic [NUM_PORTS-1:0]       lane_sec,
    input  logic                       dbg_inv_en,
    input  logic                       dbg_sec_en,
    input  logic                       dbg_ns_en,
    output logic [NUM_PORTS-1:0]       ev_vld,
    output logic [NUM_PORTS*EVT_W-1:0] ev_num
);
    logic sec_ok;
    logic ns_ok;

    // Authentication terms shared by every lane.
    assign sec_ok = dbg_inv_en & dbg_sec_en;
    assign ns_ok  = dbg_inv_en & dbg_ns_en;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        logic [EVT_W-1:0] num;
        // Table lookup for this lane.
        assign num = evt_of(lane_txn[p*TXN_W +: TXN_W]);
        assign ev_num[p*EVT_W +: EVT_W] = num;
        // Qualify with valid, non-null event and security permission.
        assign ev_vld[p] = lane_vld[p] && (num != '0)
                           && (lane_sec[p] ? sec_ok : ns_ok);
    end
endmodule

// File: rtl/ic_evt_counter.sv
// One event counter: lane matching, multi-hit adder, sticky wrap flag.
// Assumes clr_all and ld are never both asserted. Priority of updates:
// clear-all, then load, then increment.
module ic_evt_counter
    import ic_evt_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int CNT_W     = 32,
    parameter int PORT_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [EVT_W-1:0]           sel_evt,
    input  logic                       sel_any,
    input  logic [PORT_W-1:0]          sel_port,
    input  logic [NUM_PORTS-1:0]       ev_vld,
    input  logic [NUM_PORTS*EVT_W-1:0] ev_num,
    input  logic                       clr_all,
    input  logic                       ld,
    input  logic [CNT_W-1:0]           ld_val,
    input  logic                       ovf_clr,
    output logic [CNT_W-1:0]           cnt,
    output logic                       ovf
);
    localparam int INC_W = $clog2(NUM_PORTS + 1);
    localparam int SUM_W = CNT_W + 1;

    logic [NUM_PORTS-1:0] hit;
    logic [INC_W-1:0]     inc;
    logic [SUM_W-1:0]     sum;
    logic                 wrap;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_match
        // Lane p matches on event number and lane selection.
        assign hit[p] = ev_vld[p] && (ev_num[p*EVT_W +: EVT_W] == sel_evt)
                        && (sel_any || (sel_port == PORT_W'(p)));
    end

    // Count the matching lanes of this cycle.
    always_comb begin
        inc = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            inc = inc + INC_W'(hit[p]);
        end
    end

    assign sum  = {1'b0, cnt} + SUM_W'(inc);
    assign wrap = run && sum[CNT_W];

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr_all) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (run) begin
            cnt <= sum[CNT_W-1:0];
        end
    end

    // Sticky wrap flag; a wrap beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wrap && !clr_all && !ld) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/ic_evt_regs.sv
// Register file: control, flag, config and value access.
// Word accesses only; byte and halfword writes are dropped and such
// reads return zero. Read data is registered one cycle after request.
module ic_evt_regs
    import ic_evt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 32,
    parameter int PORT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     wr,
    input  logic [IDX_W-1:0]         idx,
    input  logic [1:0]               size,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input  logic [NUM_CNT-1:0]       ovf,
    output logic                     glb_en,
    output logic                     clr_all,
    output logic [NUM_CNT-1:0]       cfg_en,
    output logic [NUM_CNT*EVT_W-1:0] cfg_evt,
    output logic [NUM_CNT-1:0]       cfg_any,
    output logic [NUM_CNT*PORT_W-1:0] cfg_port,
    output logic [NUM_CNT-1:0]       cnt_ld,
    output logic [NUM_CNT-1:0]       ovf_clr,
    output logic                     rvalid,
    output logic [DATA_W-1:0]        rdata
);
    logic              word_ok;
    logic              wr_ok;
    logic              rd_fire;
    logic [NUM_CNT-1:0] cfg_hit;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign word_ok = (size == SIZE_WORD);
    assign wr_ok   = req && wr && word_ok;
    assign rd_fire = req && !wr;
    assign clr_all = wr_ok && (idx == IDX_CTRL) && wdata[1];
    assign ovf_clr = (wr_ok && (idx == IDX_OVF)) ? wdata[NUM_CNT-1:0] : '0;
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        // Per-counter write strobes for config and value.
        assign cfg_hit[i] = wr_ok && (idx == IDX_W'(CFG_BASE + i));
        assign cnt_ld[i]  = wr_ok && (idx == IDX_W'(VAL_BASE + i));
    end

    // Global enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
        end else if (wr_ok && (idx == IDX_CTRL)) begin
            glb_en <= wdata[0];
        end
    end

    // Per-counter configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= '0;
            cfg_evt  <= '0;
            cfg_any  <= '0;
            cfg_port <= '0;
        end else begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (cfg_hit[i]) begin
                    cfg_en[i]                     <= wdata[CFG_EN_BIT];
                    cfg_evt[i*EVT_W +: EVT_W]     <= wdata[CFG_EVT_LSB +: EVT_W];
                    cfg_any[i]                    <= wdata[CFG_ANY_BIT];
                    cfg_port[i*PORT_W +: PORT_W]  <= wdata[CFG_PORT_LSB +: PORT_W];
                end
            end
        end
    end

    // Read multiplexer; sub-word reads and unmapped indices give zero.
    always_comb begin
        rd_mux = '0;
        if (word_ok) begin
            if (idx == IDX_CTRL) begin
                rd_mux[0] = glb_en;
            end else if (idx == IDX_OVF) begin
                rd_mux = DATA_W'(ovf);
            end
            for (int i = 0; i < NUM_CNT; i++) begin
                if (idx == IDX_W'(CFG_BASE + i)) begin
                    rd_mux[CFG_EN_BIT]                = cfg_en[i];
                    rd_mux[CFG_EVT_LSB +: EVT_W]      = cfg_evt[i*EVT_W +: EVT_W];
                    rd_mux[CFG_ANY_BIT]               = cfg_any[i];
                    rd_mux[CFG_PORT_LSB +: PORT_W]    = cfg_port[i*PORT_W +: PORT_W];
                end
                if (idx == IDX_W'(VAL_BASE + i)) begin
                    rd_mux = DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
                end
            end
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_fire;
            rdata  <= rd_fire ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/ic_evt_monitor.sv
// Top: upstream event counter unit for a coherent interconnect.
// Assumes NUM_CNT <= 8 and CNT_W <= 32 so the register map fits the
// 5-bit index and 32-bit data path.
module ic_evt_monitor
    import ic_evt_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int NUM_CNT   = 8,
    parameter int CNT_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       up_vld,
    input  logic [NUM_PORTS*TXN_W-1:0] up_txn,
    input  logic [NUM_PORTS-1:0]       up_sec,
    input  logic                       dbg_inv_en,
    input  logic                       dbg_sec_en,
    input  logic                       dbg_ns_en,
    input  logic                       reg_req,
    input  logic                       reg_wr,
    input  logic [IDX_W-1:0]           reg_idx,
    input  logic [1:0]                 reg_size,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic                       reg_rvalid,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic [NUM_CNT-1:0]         cnt_ovf
);
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_PORTS-1:0]       ev_vld;
    logic [NUM_PORTS*EVT_W-1:0] ev_num;
    logic                       glb_en;
    logic                       clr_all;
    logic [NUM_CNT-1:0]         cfg_en;
    logic [NUM_CNT*EVT_W-1:0]   cfg_evt;
    logic [NUM_CNT-1:0]         cfg_any;
    logic [NUM_CNT*PORT_W-1:0]  cfg_port;
    logic [NUM_CNT-1:0]         cnt_ld;
    logic [NUM_CNT-1:0]         ovf_clr;
    logic [NUM_CNT*CNT_W-1:0]   cnt_flat;

    ic_evt_lane_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .lane_vld   (up_vld),
        .lane_txn   (up_txn),
        .lane_sec   (up_sec),
        .dbg_inv_en (dbg_inv_en),
        .dbg_sec_en (dbg_sec_en),
        .dbg_ns_en  (dbg_ns_en),
        .ev_vld     (ev_vld),
        .ev_num     (ev_num)
    );

    ic_evt_regs #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (reg_req),
        .wr       (reg_wr),
        .idx      (reg_idx),
        .size     (reg_size),
        .wdata    (reg_wdata),
        .cnt_flat (cnt_flat),
        .ovf      (cnt_ovf),
        .glb_en   (glb_en),
        .clr_all  (clr_all),
        .cfg_en   (cfg_en),
        .cfg_evt  (cfg_evt),
        .cfg_any  (cfg_any),
        .cfg_port (cfg_port),
        .cnt_ld   (cnt_ld),
        .ovf_clr  (ovf_clr),
        .rvalid   (reg_rvalid),
        .rdata    (reg_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        ic_evt_counter #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (glb_en && cfg_en[i]),
            .sel_evt  (cfg_evt[i*EVT_W +: EVT_W]),
            .sel_any  (cfg_any[i]),
            .sel_port (cfg_port[i*PORT_W +: PORT_W]),
            .ev_vld   (ev_vld),
            .ev_num   (ev_num),
            .clr_all  (clr_all),
            .ld       (cnt_ld[i]),
            .ld_val   (reg_wdata[CNT_W-1:0]),
            .ovf_clr  (ovf_clr[i]),
            .cnt      (cnt_flat[i*CNT_W +: CNT_W]),
            .ovf      (cnt_ovf[i])
        );
    end
endmodule

// File: rtl/ic_evt_monitor_chk.sv
// Checker for ic_evt_monitor: temporal properties on ports and state.
// Attached to every instance of the top through the bind below.
module ic_evt_monitor_chk
    import ic_evt_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 32,
    parameter int SNAP_W  = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dbg_inv_en,
    input logic                     reg_req,
    input logic                     reg_wr,
    input logic [IDX_W-1:0]         reg_idx,
    input logic [1:0]               reg_size,
    input logic                     reg_rvalid,
    input logic [DATA_W-1:0]        reg_rdata,
    input logic [NUM_CNT-1:0]       cnt_ovf,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [SNAP_W-1:0]        cfg_snap,
    input logic                     glb_en
);
    // R4: with invasive debug off and no register write, counters hold.
    p_hold_without_dbg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_inv_en && !(reg_req && reg_wr)) |=> $stable(cnt_flat));

    // R6: a flag only falls after a word write to the flag register.
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cnt_ovf) & ~cnt_ovf)) |->
        $past(reg_req && reg_wr && reg_idx == IDX_OVF && reg_size == SIZE_WORD));

    // R8: sub-word writes leave configuration and global enable untouched.
    p_subword_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_wr && reg_size != SIZE_WORD) |=> ($stable(cfg_snap) && $stable(glb_en)));

    // R8: sub-word reads answer zero.
    p_subword_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr && reg_size != SIZE_WORD) |=> (reg_rdata == '0));

    // R9: every read request is answered in the next cycle.
    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr) |=> reg_rvalid);

    // R9: no response without a request.
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_wr) |=> !reg_rvalid);
endmodule

bind ic_evt_monitor ic_evt_monitor_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .SNAP_W  (NUM_CNT * (2 + ic_evt_pkg::EVT_W + PORT_W))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_inv_en (dbg_inv_en),
    .reg_req    (reg_req),
    .reg_wr     (reg_wr),
    .reg_idx    (reg_idx),
    .reg_size   (reg_size),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .cnt_ovf    (cnt_ovf),
    .cnt_flat   (cnt_flat),
    .cfg_snap   ({cfg_en, cfg_evt, cfg_any, cfg_port}),
    .glb_en     (glb_en)
);

// File: tb/tb_ic_evt_monitor.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a negedge monitor
// pops and compares them against each read response.
module tb_ic_evt_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  up_vld = '0;
    logic [27:0] up_txn = '0;
    logic [6:0]  up_sec = '0;
    logic        dbg_inv_en = 1'b1;
    logic        dbg_sec_en = 1'b1;
    logic        dbg_ns_en  = 1'b1;
    logic        reg_req = 1'b0;
    logic        reg_wr  = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [1:0]  reg_size = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [31:0] reg_rdata;
    logic [7:0]  cnt_ovf;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] exp_w;
    string       tag_s;

    always #10 clk = ~clk;

    ic_evt_monitor dut (
        .clk(clk), .rst_n(rst_n), .up_vld(up_vld), .up_txn(up_txn), .up_sec(up_sec),
        .dbg_inv_en(dbg_inv_en), .dbg_sec_en(dbg_sec_en), .dbg_ns_en(dbg_ns_en),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .cnt_ovf(cnt_ovf)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read response with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: actual response %h expected none", reg_rdata);
            end else begin
                exp_w = exp_q.pop_front();
                tag_s = tag_q.pop_front();
                check(reg_rdata, exp_w, tag_s);
            end
        end
    end

    task automatic wr(input int idx, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_idx = 5'(idx); reg_wdata = d; reg_size = sz;
        @(negedge clk);
        reg_req = 0; reg_wr = 0; reg_size = 2'd2;
    endtask

    task automatic rd(input int idx, input logic [31:0] exp, input string tag,
                      input logic [1:0] sz = 2'd2);
        @(negedge clk);
        reg_req = 1; reg_wr = 0; reg_idx = 5'(idx); reg_size = sz;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        reg_req = 0; reg_size = 2'd2;
    endtask

    task automatic fire(input logic [6:0] v, input logic [27:0] t, input logic [6:0] s);
        @(negedge clk);
        up_vld = v; up_txn = t; up_sec = s;
        @(negedge clk);
        up_vld = '0; up_txn = '0; up_sec = '0;
    endtask

    // Register write and lane events in the same cycle.
    task automatic wr_fire(input int idx, input logic [31:0] d,
                           input logic [6:0] v, input logic [27:0] t);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_idx = 5'(idx); reg_wdata = d;
        up_vld = v; up_txn = t; up_sec = '0;
        @(negedge clk);
        reg_req = 0; reg_wr = 0; up_vld = '0; up_txn = '0;
    endtask

    function automatic logic [27:0] on_lane(input int p, input int code);
        return 28'(code) << (4 * p);
    endfunction

    function automatic logic [31:0] cfg(input int ev, input bit any, input int port, input bit en);
        return 32'(en) | (32'(ev) << 8) | (32'(any) << 16) | (32'(port) << 20);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check({24'b0, cnt_ovf}, 32'h0, "R10 flags");
        check({31'b0, reg_rvalid}, 32'h0, "R10 rvalid");
        rd(0, 0, "R10 ctrl");
        rd(1, 0, "R10 flag reg");
        rd(8, 0, "R10 cfg0");
        rd(16, 0, "R10 val0");

        wr(0, 1);
        wr(8,  cfg(3, 1, 0, 1));
        wr(9,  cfg(4, 0, 2, 1));
        wr(10, cfg(5, 1, 0, 1));
        wr(11, cfg(6, 1, 0, 1));
        wr(12, cfg(7, 1, 0, 1));
        wr(13, cfg(9, 1, 0, 1));
        wr(14, cfg(4, 1, 0, 1));
        wr(15, cfg(8, 1, 0, 1));

        // R1: every code once on lane 0, non-secure
        for (int c = 0; c < 16; c++) fire(7'h01, on_lane(0, c), 7'h00);
        rd(16, 1, "R1 ev3");
        rd(22, 4, "R1 ev4");
        rd(18, 2, "R1 ev5");
        rd(19, 3, "R1 ev6");
        rd(20, 1, "R1 ev7");
        rd(21, 1, "R1 ev9");
        rd(23, 0, "R1 ev8 never");
        rd(17, 0, "R2 port select");

        // R2: all lanes at once, then two lanes
        fire(7'h7F, {7{4'd2}}, 7'h00);
        rd(22, 11, "R2 all lanes");
        rd(17, 1, "R2 lane2 only");
        fire(7'h0C, on_lane(2, 1) | on_lane(3, 1), 7'h00);
        rd(22, 13, "R2 two lanes");
        rd(17, 2, "R2 lane2 pair");

        // R3: counter enable and global enable
        wr(14, cfg(4, 1, 0, 0));
        fire(7'h04, on_lane(2, 1), 7'h00);
        rd(22, 13, "R3 counter off");
        rd(17, 3, "R3 counter on");
        wr(0, 0);
        fire(7'h04, on_lane(2, 1), 7'h00);
        rd(17, 3, "R3 global off");
        wr(0, 1);

        // R4: invasive debug off
        dbg_inv_en = 0;
        fire(7'h03, 28'h0, 7'h02);
        rd(16, 1, "R4 dbg off");
        // R5: gating per security
        dbg_inv_en = 1; dbg_sec_en = 0; dbg_ns_en = 1;
        fire(7'h03, 28'h0, 7'h02);
        rd(16, 2, "R5 ns only");
        dbg_sec_en = 1; dbg_ns_en = 0;
        fire(7'h03, 28'h0, 7'h02);
        rd(16, 3, "R5 sec only");
        dbg_ns_en = 1;
        fire(7'h03, 28'h0, 7'h02);
        rd(16, 5, "R5 both");

        // R11: load, and load beats increment
        wr(16, 100);
        rd(16, 100, "R11 load");
        wr_fire(16, 50, 7'h01, on_lane(0, 0));
        rd(16, 50, "R11 load wins");

        // R6: wrap sets sticky flag
        wr(18, 32'hFFFF_FFFE);
        fire(7'h03, on_lane(0, 5) | on_lane(1, 5), 7'h00);
        check({24'b0, cnt_ovf}, 32'h04, "R6 wrap flag");
        rd(18, 0, "R6 wrapped value");
        rd(1, 32'h04, "R6 flag reg");
        wr(19, 32'hFFFF_FFFF);
        wr_fire(1, 32'h0C, 7'h01, on_lane(0, 7));
        check({24'b0, cnt_ovf}, 32'h08, "R6 set beats clear");

        // R7: reset-all
        wr(0, 3);
        rd(0, 1, "R7 ctrl readback");
        check({24'b0, cnt_ovf}, 32'h08, "R7 flags kept");
        rd(17, 0, "R7 val1");
        rd(22, 0, "R7 val6");
        rd(16, 0, "R7 val0");
        wr(1, 32'h08);
        check({24'b0, cnt_ovf}, 32'h0, "R6 clear");

        // R8: sub-word accesses
        wr(8, 0, 2'd0);
        rd(8, cfg(3, 1, 0, 1), "R8 byte write ignored");
        rd(8, 0, "R8 half read", 2'd1);
        wr(0, 0, 2'd1);
        rd(0, 1, "R8 half write ignored");

        // R9: map and unused locations
        rd(5, 0, "R9 unmapped");
        rd(31, 0, "R9 top index");
        rd(9, cfg(4, 0, 2, 1), "R9 cfg fields");

        repeat (3) @(negedge clk);
        check(32'(exp_q.size()), 0, "R9 all answered");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule